// File: doc/BRIEF.md
# Quadrature Position Counter with Index Handling

This block turns two quadrature phase inputs and an index input into a position count. It counts in x4 resolution, one count for every edge on either phase input. The direction of each count comes from the order in which the phases change. A separate index state machine watches for rising edges on the index input. It reports each such edge as a one-cycle strobe, keeps a sticky first-index flag, and, depending on a two-bit reset-mode input, clears the position counter.

The count always stays within the range 0 to `pos_max`. When it steps past either end it wraps around. When both phases change in the same cycle, the phase error output pulses and no count is made.

The index edge takes effect in the same clock edge at which it is sampled. Nothing in the block gates it against counting activity. An index edge that arrives one cycle before, in the same cycle as, or up to two cycles after a phase edge is therefore always detected and acted on.

Two state machines make up the block:

- **Phase tracker** (`phase_e`).
  - It starts in `PH_INIT`. The first sample after reset is taken as the reference level and makes no count (transition *capture*).
  - After that it is always in `PH_00`, `PH_10`, `PH_11` or `PH_01`, named by the {A,B} level it last sampled.
  - Moves `PH_00→PH_10→PH_11→PH_01→PH_00` are *forward* steps.
  - The reverse moves are *backward* steps.
  - A move to the diagonally opposite state is a *skip* and counts as an error.
  - Staying in the same state is a *hold*.
- **Index tracker** (`idx_e`).
  - `IX_ARMED` moves to `IX_MARKED` on an index rising edge (transition *mark*).
  - `IX_MARKED` returns to `IX_ARMED` when `flag_clr` is high and no index edge occurs in that cycle (transition *rearm*).

Top module: `quad_pos_counter`

## Requirements
- R1: Phase levels are read as {A,B}. Each forward move (00→10, 10→11, 11→01, 01→00) adds one to `pos_count`, and each backward move subtracts one. The new count is visible after the clock edge that samples the new level.
- R2: `dir` becomes 1 after a forward step and 0 after a backward step. It holds its value otherwise and is 0 after reset.
- R3: When both phases change in one cycle, no count is made and `phase_err` is high for exactly that one cycle.
- R4: A forward step from `pos_max` (or above) gives 0. A backward step from 0 gives `pos_max`.
- R5: With `rst_mode` = 2'b00, every index rising edge clears `pos_count` to 0. If a count step falls in the same cycle, the clear wins.
- R6: With `rst_mode` = 2'b10, an index rising edge clears `pos_count` only while the first-index flag is low.
- R7: With `rst_mode` = 2'b01 or 2'b11, index edges never change `pos_count`.
- R8: `first_flag` sets on any index rising edge and stays set until `flag_clr`. If an index edge and `flag_clr` occur together, the flag ends up set. Clearing the flag re-arms first-index behaviour.
- R9: `idx_strobe` is a one-cycle pulse for each rising edge of `qi`. It is visible after the same edge at which the clear takes effect.
- R10: With `rst_mode` = 2'b00, an index rising edge one cycle before, in the same cycle as, or one or two cycles after a phase edge still clears the count.
- R11: Reset gives `pos_count`=0, `dir`=0, `first_flag`=0, `idx_strobe`=0 and `phase_err`=0. The first phase sample after reset makes no count, and `qi` already high at release is not an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| qa | input | 1 | Phase A, already synchronised |
| qb | input | 1 | Phase B, already synchronised |
| qi | input | 1 | Index, already synchronised |
| rst_mode | input | 2 | 00 every index clears, 10 first index clears, 01/11 index ignored by count |
| pos_max | input | POS_W | Highest count value before wrap |
| flag_clr | input | 1 | Clears the first-index flag |
| pos_count | output | POS_W | Position count |
| dir | output | 1 | Last count direction, 1 = forward |
| first_flag | output | 1 | First-index flag |
| idx_strobe | output | 1 | One-cycle index event pulse |
| phase_err | output | 1 | One-cycle pulse on an illegal two-phase change |

## Verification
The counting function is driven with several phase patterns, and each pattern separates a different fault:

- A full forward cycle through all four phase levels shows that each transition is decoded.
- A reversal mid-sequence shows that direction follows the transition order rather than the level.
- A diagonal skip shows that illegal moves are neither counted nor treated as holds.
- Steps across 0 and `pos_max` expose the wrap in each direction.

Index edges are placed at offsets of −1, 0, +1 and +2 cycles from a phase edge, under each reset mode. They are also placed with the flag set and cleared, including a flag clear in the same cycle. These cases separate every-index clearing, first-only clearing and ignored index edges. A final reset with both phases and the index already high shows that the first sample is taken as a reference and not as motion.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

    // Phase tracker states: {init, A, B}
    typedef enum logic [2:0] {
        PH_00   = 3'b000,
        PH_01   = 3'b001,
        PH_10   = 3'b010,
        PH_11   = 3'b011,
        PH_INIT = 3'b100
    } phase_e;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DN   = 2'd2,
        STEP_BAD  = 2'd3
    } step_e;

    typedef enum logic {
        IX_ARMED  = 1'b0,
        IX_MARKED = 1'b1
    } idx_e;

    localparam logic [1:0] MODE_EVERY = 2'b00;
    localparam logic [1:0] MODE_WRAP  = 2'b01;
    localparam logic [1:0] MODE_FIRST = 2'b10;
    localparam logic [1:0] MODE_FREE  = 2'b11;

    function automatic phase_e phase_of(input logic a, input logic b);
        unique case ({a, b})
            2'b00:   return PH_00;
            2'b01:   return PH_01;
            2'b10:   return PH_10;
            default: return PH_11;
        endcase
    endfunction

    // Position of a phase on the forward cycle 00 -> 10 -> 11 -> 01
    function automatic logic [1:0] ring_pos(input phase_e p);
        unique case (p)
            PH_10:   return 2'd1;
            PH_11:   return 2'd2;
            PH_01:   return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/qpc_phase_fsm.sv
module qpc_phase_fsm
    import qpc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  qa,
    input  logic  qb,
    output step_e step
);

    phase_e state;
    phase_e state_nx;
    logic [1:0] ring_delta;

    assign state_nx   = phase_of(qa, qb);
    assign ring_delta = ring_pos(state_nx) - ring_pos(state);

    // State register: the tracker always follows the sampled level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PH_INIT;
        end else begin
            state <= state_nx;
        end
    end

    // Step output from the current state and the incoming level
    always_comb begin
        step = STEP_NONE;
        unique case (state)
            PH_INIT: step = STEP_NONE;   // capture: reference level only
            PH_00, PH_01, PH_10, PH_11: begin
                unique case (ring_delta)
                    2'd1:    step = STEP_UP;
                    2'd3:    step = STEP_DN;
                    2'd2:    step = STEP_BAD;
                    default: step = STEP_NONE;
                endcase
            end
            default: step = STEP_NONE;
        endcase
    end

endmodule

// File: rtl/qpc_index_fsm.sv
module qpc_index_fsm
    import qpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       qi,
    input  logic [1:0] rst_mode,
    input  logic       flag_clr,
    output logic       idx_rise,
    output logic       clr_pos,
    output logic       first_flag
);

    idx_e state;
    idx_e state_nx;
    logic qi_q;

    assign idx_rise = qi & ~qi_q;

    // Edge reference: high at reset so a level held through reset is no edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qi_q <= 1'b1;
        end else begin
            qi_q <= qi;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= IX_ARMED;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            IX_ARMED:  if (idx_rise) state_nx = IX_MARKED;                 // mark
            IX_MARKED: if (flag_clr && !idx_rise) state_nx = IX_ARMED;     // rearm
            default:   state_nx = IX_ARMED;
        endcase
    end

    // Outputs
    always_comb begin
        clr_pos = 1'b0;
        unique case (rst_mode)
            MODE_EVERY: clr_pos = idx_rise;
            MODE_FIRST: clr_pos = idx_rise && (state == IX_ARMED);
            MODE_WRAP,
            MODE_FREE:  clr_pos = 1'b0;
            default:    clr_pos = 1'b0;
        endcase
    end

    assign first_flag = (state == IX_MARKED);

endmodule

// File: rtl/qpc_pos_counter.sv
module qpc_pos_counter
    import qpc_pkg::*;
#(
    parameter int POS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  step_e            step,
    input  logic             clr_pos,
    input  logic [POS_W-1:0] pos_max,
    output logic [POS_W-1:0] pos_count,
    output logic             dir
);

    localparam logic [POS_W-1:0] ONE = POS_W'(1);

    logic [POS_W-1:0] pos_nx;
    logic             dir_nx;

    always_comb begin
        pos_nx = pos_count;
        dir_nx = dir;
        unique case (step)
            STEP_UP: begin
                dir_nx = 1'b1;
                pos_nx = (pos_count >= pos_max) ? '0 : pos_count + ONE;
            end
            STEP_DN: begin
                dir_nx = 1'b0;
                pos_nx = (pos_count == '0) ? pos_max : pos_count - ONE;
            end
            STEP_BAD,
            STEP_NONE: pos_nx = pos_count;
            default:   pos_nx = pos_count;
        endcase
        if (clr_pos) begin
            pos_nx = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_count <= '0;
            dir       <= 1'b0;
        end else begin
            pos_count <= pos_nx;
            dir       <= dir_nx;
        end
    end

endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter
    import qpc_pkg::*;
#(
    parameter int POS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             qa,
    input  logic             qb,
    input  logic             qi,
    input  logic [1:0]       rst_mode,
    input  logic [POS_W-1:0] pos_max,
    input  logic             flag_clr,
    output logic [POS_W-1:0] pos_count,
    output logic             dir,
    output logic             first_flag,
    output logic             idx_strobe,
    output logic             phase_err
);

    step_e step;
    logic  idx_rise;
    logic  clr_pos;

    qpc_phase_fsm u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .qa    (qa),
        .qb    (qb),
        .step  (step)
    );

    qpc_index_fsm u_index (
        .clk        (clk),
        .rst_n      (rst_n),
        .qi         (qi),
        .rst_mode   (rst_mode),
        .flag_clr   (flag_clr),
        .idx_rise   (idx_rise),
        .clr_pos    (clr_pos),
        .first_flag (first_flag)
    );

    qpc_pos_counter #(.POS_W(POS_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .clr_pos   (clr_pos),
        .pos_max   (pos_max),
        .pos_count (pos_count),
        .dir       (dir)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_strobe <= 1'b0;
            phase_err  <= 1'b0;
        end else begin
            idx_strobe <= idx_rise;
            phase_err  <= (step == STEP_BAD);
        end
    end

endmodule

// File: rtl/qpc_checks.sv
module qpc_checks #(
    parameter int POS_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       rst_mode,
    input logic             flag_clr,
    input logic [POS_W-1:0] pos_count,
    input logic             first_flag,
    input logic             idx_strobe,
    input logic             phase_err
);

    p_every_index_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_strobe && $past(rst_mode) == 2'b00) |-> (pos_count == '0));

    p_skip_no_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_err && !idx_strobe) |-> $stable(pos_count));

    p_strobe_sets_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        idx_strobe |-> first_flag);

    p_flag_drop_needs_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(first_flag) |-> $past(flag_clr));

    p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        idx_strobe |=> !idx_strobe);

endmodule

bind quad_pos_counter qpc_checks #(.POS_W(POS_W)) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_mode   (rst_mode),
    .flag_clr   (flag_clr),
    .pos_count  (pos_count),
    .first_flag (first_flag),
    .idx_strobe (idx_strobe),
    .phase_err  (phase_err)
);

// File: tb/quad_pos_counter_bench.sv
`timescale 1ns/1ps
module quad_pos_counter_bench;

    localparam int POS_W = 16;
    localparam logic [POS_W-1:0] MAXV = 16'd9;
    localparam int NV = 28;

    // {a,b,i,mode[1:0],clr,pos[15:0],dir,flag,strobe,err}
    localparam logic [25:0] VEC [NV] = '{
        {1'b1,1'b0,1'b0,2'b01,1'b0,16'd1,1'b1,1'b0,1'b0,1'b0}, // R1 forward
        {1'b1,1'b1,1'b0,2'b01,1'b0,16'd2,1'b1,1'b0,1'b0,1'b0},
        {1'b0,1'b1,1'b0,2'b01,1'b0,16'd3,1'b1,1'b0,1'b0,1'b0},
        {1'b0,1'b0,1'b0,2'b01,1'b0,16'd4,1'b1,1'b0,1'b0,1'b0},
        {1'b0,1'b0,1'b0,2'b01,1'b0,16'd4,1'b1,1'b0,1'b0,1'b0}, // R2 hold
        {1'b0,1'b1,1'b0,2'b01,1'b0,16'd3,1'b0,1'b0,1'b0,1'b0}, // R1 backward
        {1'b1,1'b1,1'b0,2'b01,1'b0,16'd2,1'b0,1'b0,1'b0,1'b0},
        {1'b0,1'b0,1'b0,2'b01,1'b0,16'd2,1'b0,1'b0,1'b0,1'b1}, // R3 skip
        {1'b0,1'b0,1'b0,2'b01,1'b0,16'd2,1'b0,1'b0,1'b0,1'b0},
        {1'b0,1'b1,1'b0,2'b01,1'b0,16'd1,1'b0,1'b0,1'b0,1'b0},
        {1'b1,1'b1,1'b0,2'b01,1'b0,16'd0,1'b0,1'b0,1'b0,1'b0},
        {1'b1,1'b0,1'b0,2'b01,1'b0,16'd9,1'b0,1'b0,1'b0,1'b0}, // R4 wrap down
        {1'b1,1'b1,1'b0,2'b01,1'b0,16'd0,1'b1,1'b0,1'b0,1'b0}, // R4 wrap up
        {1'b0,1'b1,1'b0,2'b01,1'b0,16'd1,1'b1,1'b0,1'b0,1'b0},
        {1'b0,1'b0,1'b0,2'b01,1'b0,16'd2,1'b1,1'b0,1'b0,1'b0},
        {1'b0,1'b0,1'b1,2'b01,1'b0,16'd2,1'b1,1'b1,1'b1,1'b0}, // R7 no clear
        {1'b0,1'b0,1'b0,2'b01,1'b0,16'd2,1'b1,1'b1,1'b0,1'b0},
        {1'b0,1'b0,1'b1,2'b10,1'b0,16'd2,1'b1,1'b1,1'b1,1'b0}, // R6 not first
        {1'b0,1'b0,1'b0,2'b10,1'b1,16'd2,1'b1,1'b0,1'b0,1'b0}, // R8 clear
        {1'b1,1'b0,1'b0,2'b10,1'b0,16'd3,1'b1,1'b0,1'b0,1'b0},
        {1'b1,1'b0,1'b1,2'b10,1'b0,16'd0,1'b1,1'b1,1'b1,1'b0}, // R6 first
        {1'b1,1'b1,1'b0,2'b10,1'b0,16'd1,1'b1,1'b1,1'b0,1'b0},
        {1'b1,1'b1,1'b1,2'b10,1'b0,16'd1,1'b1,1'b1,1'b1,1'b0}, // R6 second
        {1'b0,1'b1,1'b0,2'b10,1'b0,16'd2,1'b1,1'b1,1'b0,1'b0},
        {1'b0,1'b1,1'b1,2'b00,1'b0,16'd0,1'b1,1'b1,1'b1,1'b0}, // R5 every
        {1'b0,1'b0,1'b0,2'b00,1'b0,16'd1,1'b1,1'b1,1'b0,1'b0},
        {1'b1,1'b0,1'b1,2'b00,1'b0,16'd0,1'b1,1'b1,1'b1,1'b0}, // R5 R10 same cycle
        {1'b1,1'b0,1'b0,2'b00,1'b0,16'd0,1'b1,1'b1,1'b0,1'b0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             qa = 1'b0, qb = 1'b0, qi = 1'b0;
    logic [1:0]       rst_mode = 2'b01;
    logic [POS_W-1:0] pos_max = MAXV;
    logic             flag_clr = 1'b0;
    logic [POS_W-1:0] pos_count;
    logic             dir, first_flag, idx_strobe, phase_err;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    quad_pos_counter #(.POS_W(POS_W)) u_quad_pos_counter (
        .clk(clk), .rst_n(rst_n), .qa(qa), .qb(qb), .qi(qi),
        .rst_mode(rst_mode), .pos_max(pos_max), .flag_clr(flag_clr),
        .pos_count(pos_count), .dir(dir), .first_flag(first_flag),
        .idx_strobe(idx_strobe), .phase_err(phase_err)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic apply(input logic a, input logic b, input logic i,
                         input logic [1:0] m, input logic c);
        @(negedge clk);
        qa = a; qb = b; qi = i; rst_mode = m; flag_clr = c;
        @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R11 pos in reset", pos_count, 0);
        check("R11 flag in reset", first_flag, 0);
        check("R11 dir in reset", dir, 0);
        @(negedge clk);
        rst_n = 1'b1;
        apply(1'b0, 1'b0, 1'b0, 2'b01, 1'b0);
        check("R11 pos after capture", pos_count, 0);

        for (int k = 0; k < NV; k++) begin
            logic [25:0] v;
            v = VEC[k];
            apply(v[25], v[24], v[23], v[22:21], v[20]);
            check($sformatf("R1 pos row %0d", k), pos_count, v[19:4]);
            check($sformatf("R2 dir row %0d", k), dir, v[3]);
            check($sformatf("R8 flag row %0d", k), first_flag, v[2]);
            check($sformatf("R9 strobe row %0d", k), idx_strobe, v[1]);
            check($sformatf("R3 err row %0d", k), phase_err, v[0]);
        end

        // R10 index one cycle before a phase edge (state 10, pos 0)
        apply(1'b1, 1'b0, 1'b1, 2'b00, 1'b0);
        check("R10 early index clear", pos_count, 0);
        check("R9 early strobe", idx_strobe, 1);
        apply(1'b1, 1'b1, 1'b1, 2'b00, 1'b0);
        check("R10 count after early index", pos_count, 1);
        check("R9 strobe one cycle", idx_strobe, 0);
        apply(1'b1, 1'b1, 1'b0, 2'b00, 1'b0);
        // R10 index one cycle after
        apply(1'b0, 1'b1, 1'b0, 2'b00, 1'b0);
        check("R10 pre +1 count", pos_count, 2);
        apply(1'b0, 1'b1, 1'b1, 2'b00, 1'b0);
        check("R10 index +1 clear", pos_count, 0);
        apply(1'b0, 1'b1, 1'b0, 2'b00, 1'b0);
        // R10 index two cycles after
        apply(1'b0, 1'b0, 1'b0, 2'b00, 1'b0);
        check("R10 pre +2 count", pos_count, 1);
        apply(1'b0, 1'b0, 1'b0, 2'b00, 1'b0);
        apply(1'b0, 1'b0, 1'b1, 2'b00, 1'b0);
        check("R10 index +2 clear", pos_count, 0);
        // R8 clear with index while set
        apply(1'b0, 1'b0, 1'b0, 2'b00, 1'b0);
        apply(1'b0, 1'b0, 1'b1, 2'b00, 1'b1);
        check("R8 set wins over clear", first_flag, 1);
        apply(1'b0, 1'b0, 1'b0, 2'b00, 1'b1);
        check("R8 clear drops flag", first_flag, 0);
        apply(1'b0, 1'b0, 1'b1, 2'b00, 1'b1);
        check("R8 armed index with clear sets", first_flag, 1);

        // R11 reset with inputs already high
        @(negedge clk);
        rst_n = 1'b0; qa = 1'b1; qb = 1'b1; qi = 1'b1; flag_clr = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        check("R11 pos reset again", pos_count, 0);
        check("R11 strobe in reset", idx_strobe, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        check("R11 no count on capture", pos_count, 0);
        check("R11 high index is no edge", idx_strobe, 0);
        check("R11 no error on capture", phase_err, 0);
        apply(1'b0, 1'b1, 1'b1, 2'b00, 1'b0);
        check("R11 first step after capture", pos_count, 1);
        check("R2 dir after capture step", dir, 1);
        apply(1'b0, 1'b1, 1'b0, 2'b00, 1'b0);
        apply(1'b0, 1'b1, 1'b1, 2'b00, 1'b0);
        check("R5 clear after reset", pos_count, 0);
        check("R8 flag after reset index", first_flag, 1);

        finish_run();
    end

endmodule